// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 sixteen-bit words. Each host request is one word, a read or a write, and a two-bit lane mask picks which bytes take part. The controller registers the request and then drives the memory's active-low strobes through a fixed sequence of phases. The number of clocks in each phase is a parameter, so the memory's access and cycle times can be met at whatever clock the host runs on.

Only one access is in flight at a time. The host sees `req_ready` low from the clock that accepts a request until that access has finished. A read returns its word with a single-cycle `rsp_valid` pulse. The shared data bus appears as separate out, in and drive-enable signals. The controller turns its own drivers on only inside a write, and only once the memory's outputs have been off for at least one clock. Its drivers are already off again in the clock before any read turns the memory's outputs on.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and every bit of `mem_be_n` are 1. In the same cycles `mem_dq_oe` and `rsp_valid` are 0 and `req_ready` is 1. Reset is synchronous and active high, and it aborts any access in progress.
- R2: In a read, `mem_ce_n` and `mem_oe_n` are 0 and `mem_we_n` is 1 for RD_WAIT clocks. The word on `mem_dq_in` is sampled at the end of the last of those clocks, while `mem_oe_n` is still low. `mem_addr` equals the accepted address throughout.
- R3: A write has three parts. First come WR_SETUP clocks with `mem_ce_n` 0 and `mem_we_n` 1. Then `mem_we_n` is 0 for exactly WR_PULSE clocks. Then `mem_we_n` returns to 1, and the memory stores the word on that rising edge.
- R4: Mask bit 0 drives `mem_be_n[0]`, which gates data bits 7:0. Mask bit 1 drives `mem_be_n[1]`, which gates bits 15:8. A lane whose mask bit is 0 keeps its old contents on a write, and a mask of 00 changes nothing. `mem_be_n` is all ones whenever `mem_ce_n` is 1.
- R5: In read data, a lane whose mask bit is 0 is returned as zero.
- R6: `req_ready` is 1 only in idle. A read keeps it low for RD_WAIT cycles. A write keeps it low for WR_SETUP+WR_PULSE+WR_HOLD cycles.
- R7: `mem_dq_oe` is 1 only when `mem_oe_n` has been 1 in both the current clock and the one before. `mem_oe_n` and `mem_we_n` are never low together. `mem_dq_oe` is 0 in the clock before `mem_oe_n` falls.
- R8: On the clock where `mem_we_n` rises, `mem_addr` and `mem_dq_out` are unchanged from the previous clock, `mem_ce_n` is still 0 and the drivers are still on. This holds for WR_HOLD clocks.
- R9: `rsp_valid` is a single-cycle pulse that appears once per read, in the first cycle that `req_ready` is high again. It never appears for a write.
- R10: A request presented while `req_ready` is 0 is ignored. It does not change the memory, and `mem_addr` stays constant during a busy cycle.
- R11: Reset asserted in the middle of a write, before `mem_we_n` has fallen, leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | LANES | Byte-lane mask, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | LANES | Byte-lane enables, active low, bit 0 lower |
| mem_dq_out | output | DATA_W | Data bus value driven by controller |
| mem_dq_in | input | DATA_W | Data bus value seen from memory |
| mem_dq_oe | output | 1 | Controller drives data bus when high |

## Verification
The bench goes after several ways the read and write timing can go wrong. Its memory model presents valid read data only once output enable has been low for the full wait count. A controller that samples one clock early therefore returns the model's filler pattern. A write strobe that is one clock too short or too long is caught at its rising edge, as is an address or data value that moves on that edge, which would store into the wrong word. The bench also checks read lane masking (a missing zero shows the filler byte) and partial-lane and empty-mask writes. It checks requests presented while the controller is busy, which a wrongly gated accept would execute. It applies a reset during write setup, which would corrupt a word if the strobes were not forced inactive.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_WSETUP = 3'd2,
      ST_WPULSE = 3'd3,
      ST_WHOLD  = 3'd4
   } seq_state_e;

   // Pin-level strobe set, active-low controls plus bus drive enable
   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drive;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

   function automatic strobe_t strobes_for(input seq_state_e st);
      strobe_t s;
      s = STROBE_IDLE;
      case (st)
         ST_READ:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
         ST_WSETUP: begin s.ce_n = 1'b0; end
         ST_WPULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
         ST_WHOLD:  begin s.ce_n = 1'b0; s.drive = 1'b1; end
         default:   s = STROBE_IDLE;
      endcase
      return s;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
   parameter int unsigned LANES          = 2,
   parameter int unsigned LANE_W         = 8,
   parameter bit          ZERO_OFF_LANES = 1'b1,
   localparam int unsigned DW            = LANES * LANE_W
) (
   input  logic             active,
   input  logic [LANES-1:0] mask,
   input  logic [LANES-1:0] rd_mask,
   input  logic [DW-1:0]    raw_rd,
   output logic [LANES-1:0] be_n,
   output logic [DW-1:0]    rd_gated
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be_n[i] = ~(active & mask[i]);
      if (ZERO_OFF_LANES) begin : g_zero
         assign rd_gated[i*LANE_W +: LANE_W] = rd_mask[i] ? raw_rd[i*LANE_W +: LANE_W] : '0;
      end else begin : g_pass
         logic unused_m;
         assign unused_m = rd_mask[i];
         assign rd_gated[i*LANE_W +: LANE_W] = raw_rd[i*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned RD_WAIT  = 3,
   parameter int unsigned WR_SETUP = 1,
   parameter int unsigned WR_PULSE = 2,
   parameter int unsigned WR_HOLD  = 1
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    start,
   input  logic    start_write,
   output logic    idle,
   output logic    sample,
   output logic    active_next,
   output strobe_t strobes
);

   localparam int unsigned MAXC = max4(RD_WAIT, WR_SETUP, WR_PULSE, WR_HOLD);
   localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CW-1:0] L_RD = CW'(RD_WAIT - 1);
   localparam logic [CW-1:0] L_WS = CW'(WR_SETUP - 1);
   localparam logic [CW-1:0] L_WP = CW'(WR_PULSE - 1);
   localparam logic [CW-1:0] L_WH = CW'(WR_HOLD - 1);

   seq_state_e    state_q, state_d;
   logic          load, expire;
   logic [CW-1:0] load_val;
   strobe_t       strobes_q;

   sram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val),
      .expire   (expire)
   );

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               load = 1'b1;
               if (start_write) begin
                  state_d  = ST_WSETUP;
                  load_val = L_WS;
               end else begin
                  state_d  = ST_READ;
                  load_val = L_RD;
               end
            end
         end
         ST_READ: begin
            if (expire) state_d = ST_IDLE;
         end
         ST_WSETUP: begin
            if (expire) begin
               state_d  = ST_WPULSE;
               load     = 1'b1;
               load_val = L_WP;
            end
         end
         ST_WPULSE: begin
            if (expire) begin
               state_d  = ST_WHOLD;
               load     = 1'b1;
               load_val = L_WH;
            end
         end
         ST_WHOLD: begin
            if (expire) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // Strobes are registered from the next state so each pin leaves a flop
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         strobes_q <= STROBE_IDLE;
      end else begin
         state_q   <= state_d;
         strobes_q <= strobes_for(state_d);
      end
   end

   assign idle        = (state_q == ST_IDLE);
   assign sample      = (state_q == ST_READ) && expire;
   assign active_next = (state_d != ST_IDLE);
   assign strobes     = strobes_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 17,
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned LANE_W         = 8,
   parameter int unsigned CLK_PS         = 4000,
   parameter int unsigned T_ACC_PS       = 10000,
   parameter int unsigned T_OEA_PS       = 4000,
   parameter int unsigned RD_WAIT        = 3,
   parameter int unsigned WR_SETUP       = 1,
   parameter int unsigned WR_PULSE       = 2,
   parameter int unsigned WR_HOLD        = 1,
   parameter bit          ZERO_OFF_LANES = 1'b1,
   localparam int unsigned LANES         = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int unsigned WR_TOTAL = WR_SETUP + WR_PULSE + WR_HOLD;

   // Elaboration-time parameter checks
   if (LANES * LANE_W != DATA_W) begin : g_err_lanes
      $error("DATA_W must be a whole number of LANE_W lanes");
   end
   if (RD_WAIT < 1 || WR_SETUP < 1 || WR_PULSE < 1 || WR_HOLD < 1) begin : g_err_min
      $error("every phase count must be at least one clock");
   end
   if (RD_WAIT * CLK_PS < T_ACC_PS) begin : g_err_acc
      $error("RD_WAIT too short for address access time");
   end
   if (RD_WAIT * CLK_PS < T_OEA_PS) begin : g_err_oea
      $error("RD_WAIT too short for output enable access time");
   end
   if (WR_TOTAL * CLK_PS < T_ACC_PS) begin : g_err_wcyc
      $error("write phases too short for memory cycle time");
   end

   logic              accept;
   logic              seq_idle, rd_sample, active_next;
   strobe_t           strb;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q, mask_next, be_n_d, be_n_q;
   logic [DATA_W-1:0] rd_gated;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   assign accept    = req_valid & seq_idle;
   assign mask_next = accept ? req_mask : mask_q;

   // Request capture: held constant until the next acceptance
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   sram_seq #(
      .RD_WAIT  (RD_WAIT),
      .WR_SETUP (WR_SETUP),
      .WR_PULSE (WR_PULSE),
      .WR_HOLD  (WR_HOLD)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start       (accept),
      .start_write (req_write),
      .idle        (seq_idle),
      .sample      (rd_sample),
      .active_next (active_next),
      .strobes     (strb)
   );

   sram_lane_gate #(
      .LANES          (LANES),
      .LANE_W         (LANE_W),
      .ZERO_OFF_LANES (ZERO_OFF_LANES)
   ) u_lanes (
      .active   (active_next),
      .mask     (mask_next),
      .rd_mask  (mask_q),
      .raw_rd   (mem_dq_in),
      .be_n     (be_n_d),
      .rd_gated (rd_gated)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         be_n_q      <= '1;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         be_n_q      <= be_n_d;
         rsp_valid_q <= rd_sample;
         if (rd_sample) rsp_rdata_q <= rd_gated;
      end
   end

   assign req_ready  = seq_idle;
   assign rsp_valid  = rsp_valid_q;
   assign rsp_rdata  = rsp_rdata_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = strb.ce_n;
   assign mem_oe_n   = strb.oe_n;
   assign mem_we_n   = strb.we_n;
   assign mem_dq_oe  = strb.drive;
   assign mem_be_n   = be_n_q;
   assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) &&
                      !mem_dq_oe && req_ready && !rsp_valid));

   assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   assert_write_needs_ce_R3: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> !mem_ce_n);

   assert_lanes_idle_R4: assert property (@(posedge clk) disable iff (rst)
      mem_ce_n |-> (&mem_be_n));

   assert_busy_selects_R6: assert property (@(posedge clk) disable iff (rst)
      !req_ready |-> !mem_ce_n);

   assert_drive_after_oe_R7: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

   assert_oe_we_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      !(!mem_oe_n && !mem_we_n));

   assert_release_before_oe_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe));

   assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);

   assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LANES  (LANES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_be_n   (mem_be_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

   localparam int AW       = 8;
   localparam int DW       = 16;
   localparam int DEPTH    = 1 << AW;
   localparam int RD_WAIT  = 3;
   localparam int WR_SETUP = 1;
   localparam int WR_PULSE = 2;
   localparam int WR_HOLD  = 1;
   localparam int WR_TOT   = WR_SETUP + WR_PULSE + WR_HOLD;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]    mem_be_n;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   always #2 clk = ~clk;

   sram_async_ctrl #(
      .ADDR_W (AW), .DATA_W (DW), .LANE_W (8), .CLK_PS (4000),
      .RD_WAIT (RD_WAIT), .WR_SETUP (WR_SETUP), .WR_PULSE (WR_PULSE), .WR_HOLD (WR_HOLD)
   ) dut (
      .clk (clk), .rst (rst),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_mask (req_mask),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
      .mem_be_n (mem_be_n), .mem_dq_out (mem_dq_out), .mem_dq_in (mem_dq_in), .mem_dq_oe (mem_dq_oe)
   );

   // Memory model: stores on the rising write strobe, data valid after full access delay
   logic [DW-1:0] sram_arr [DEPTH];
   logic [DW-1:0] exp_mem  [DEPTH];
   logic          prev_we = 1'b1, prev_oe = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dq = '0;
   logic [1:0]    prev_be = 2'b11;
   int            we_len = 0, oe_cnt = 0;
   int            mon_checks = 0, mon_fails = 0;
   int            checks = 0, fails = 0;

   always_comb begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
         for (int i = 0; i < 2; i++) begin
            if (!mem_be_n[i] && oe_cnt >= RD_WAIT) mem_dq_in[i*8 +: 8] = sram_arr[mem_addr][i*8 +: 8];
            else mem_dq_in[i*8 +: 8] = 8'h5C;
         end
      end else begin
         mem_dq_in = 16'hF00F;
      end
   end

   always @(negedge clk) begin
      if (rst) begin
         prev_we = 1'b1; prev_oe = 1'b1; we_len = 0; oe_cnt = 0;
      end else begin
         if (mem_dq_oe) begin
            mon_checks++;
            if (!(mem_oe_n && prev_oe)) begin
               mon_fails++;
               $display("FAIL R7 drive while oe active: actual oe_n=%b prev=%b expected 1/1", mem_oe_n, prev_oe);
            end
         end
         if (!mem_we_n) we_len = we_len + 1;
         if (!prev_we && mem_we_n) begin
            mon_checks++;
            if (!(!mem_ce_n && mem_dq_oe && mem_addr == prev_addr && mem_dq_out == prev_dq)) begin
               mon_fails++;
               $display("FAIL R8 hold at strobe rise: actual addr=%h dq=%h ce_n=%b oe=%b expected addr=%h dq=%h ce_n=0 oe=1",
                        mem_addr, mem_dq_out, mem_ce_n, mem_dq_oe, prev_addr, prev_dq);
            end
            mon_checks++;
            if (we_len != WR_PULSE) begin
               mon_fails++;
               $display("FAIL R3 write pulse length: actual=%0d expected=%0d", we_len, WR_PULSE);
            end
            for (int i = 0; i < 2; i++)
               if (!prev_be[i]) sram_arr[prev_addr][i*8 +: 8] = prev_dq[i*8 +: 8];
            we_len = 0;
         end
         oe_cnt    = !mem_oe_n ? oe_cnt + 1 : 0;
         prev_we   = mem_we_n;
         prev_oe   = mem_oe_n;
         prev_addr = mem_addr;
         prev_dq   = mem_dq_out;
         prev_be   = mem_be_n;
      end
   end

   function automatic logic [DW-1:0] pat(input int a);
      return 16'(a * 40503) ^ 16'h3C5A;
   endfunction

   function automatic logic [DW-1:0] lane_mask(input logic [1:0] m);
      return {{8{m[1]}}, {8{m[0]}}};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d, input logic [1:0] m);
      int busy;
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 0;
      while (!req_ready && busy < 40) begin busy++; @(negedge clk); end
      chk(busy == WR_TOT, "R6 write busy cycles", busy, WR_TOT);
      chk(rsp_valid == 1'b0, "R9 no response after write", rsp_valid, 0);
      exp_mem[a] = (exp_mem[a] & ~lane_mask(m)) | (d & lane_mask(m));
   endtask

   task automatic do_read(input int a, input logic [1:0] m, input string tag);
      int busy;
      logic [DW-1:0] e;
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 0;
      while (!req_ready && busy < 40) begin busy++; @(negedge clk); end
      chk(busy == RD_WAIT, "R6 read busy cycles", busy, RD_WAIT);
      chk(rsp_valid == 1'b1, "R9 read valid pulse", rsp_valid, 1);
      e = exp_mem[a] & lane_mask(m);
      chk(rsp_rdata == e, tag, rsp_rdata, e);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 valid lasts one cycle", rsp_valid, 0);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         $display("FAIL watchdog expired: actual cycles=%0d expected below 150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
      repeat (3) @(negedge clk);
      // R1: in reset
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
          "R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid}, 8'b11111010);
      rst = 1'b0;
      @(negedge clk);
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
          "R1 after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid}, 8'b11111010);

      // R3 / R2: full sweep write then read
      for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), 2'b11);
      for (int a = 0; a < DEPTH; a++) do_read(a, 2'b11, "R2 sweep read data");

      // R4: partial lanes and empty mask
      for (int a = 0; a < 64; a++) begin
         logic [1:0] m;
         case (a % 4)
            0: m = 2'b01;
            1: m = 2'b10;
            2: m = 2'b11;
            default: m = 2'b00;
         endcase
         do_write(a, ~pat(a) ^ 16'h0F0F, m);
      end
      for (int a = 0; a < 64; a++) do_read(a, 2'b11, "R4 lane write merge");

      // R5: masked read lanes return zero
      for (int a = 64; a < 80; a++) do_read(a, 2'b01, "R5 lower-only read");
      for (int a = 80; a < 96; a++) do_read(a, 2'b10, "R5 upper-only read");
      for (int a = 96; a < 100; a++) do_read(a, 2'b00, "R5 empty-mask read");

      // R10: requests held while busy are ignored
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd200; req_wdata = 16'hBEEF; req_mask = 2'b11;
      @(negedge clk);
      req_addr = 8'd201; req_wdata = 16'h1234;
      for (int k = 1; k < WR_TOT; k++) begin
         chk(req_ready == 1'b0, "R10 busy during write", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready after write", req_ready, 1);
      exp_mem[200] = 16'hBEEF;
      do_read(201, 2'b11, "R10 busy request not executed");
      do_read(200, 2'b11, "R10 first write landed");

      // R11: reset during write setup leaves memory intact
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd202; req_wdata = 16'hDEAD; req_mask = 2'b11;
      @(negedge clk);
      req_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
          "R11 strobes after mid-cycle reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid}, 8'b11111010);
      rst = 1'b0;
      @(negedge clk);
      do_read(202, 2'b11, "R11 word unchanged after abort");

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
      $finish;
   end

endmodule